// File: doc/BRIEF.md
# Descriptor-Ring Fly-By DMA Channel

This block is one DMA channel that moves a peripheral data stream to or from system memory without the CPU touching the data. Software sets up a ring of buffer descriptors in a small descriptor store inside the block, picks a direction and pulses an enable. The channel then works through the ring one descriptor at a time. In fill direction it writes incoming peripheral words into the buffer. In empty direction it reads buffer words from memory and hands them to the peripheral. When a buffer is finished the channel retires its descriptor: it flips the ownership flag, records packet-end and peripheral status, and may raise an interrupt.

Ownership moves through a full flag in each descriptor. A fill uses only buffers that are not full, and an empty uses only buffers that are full. When the next descriptor is in the wrong state, the channel parks idle and waits for software to pulse the enable again. The transfer unit is one data word, and descriptor lengths count words.

Descriptor word layout (64 bits): [63:48] buffer address, [47:36] length in words (1 or more), [35] interrupt flag, [34] last flag, [33] full flag, [32] wrap flag, [31:16] reserved, [15:0] status.

Top module: `fbdma_channel`

## Requirements
- R1: In fill direction (ctl_dir=0), the k-th word accepted into a buffer (in_valid high while in_ready is high, k counted from 0) appears one cycle later as a single-cycle memory write with mem_addr = buffer address + k and mem_wdata = the accepted word.
- R2: A fill buffer closes on the word that has in_eop high, or on the word that brings the count to the length, whichever comes first. On retire, full (bit 33) is written 1 and last (bit 34) is written equal to in_eop of the closing word.
- R3: In empty direction (ctl_dir=1), the channel reads buffer address + k for k = 0 to length-1 in order. It presents each word once on out_data with out_valid, holding it until out_ready is high. out_eop is high only with the final word of a buffer whose last flag is 1. On retire, full is written 0 and last is left unchanged.
- R4: A descriptor whose full flag is 1 in fill direction, or 0 in empty direction, causes no memory write, no output word, no interrupt and no change to any descriptor. The channel goes idle (idle=1) at that descriptor.
- R5: An idle channel stays idle, with in_ready and out_valid low, until ctl_go is pulsed. It then restarts at the descriptor index where it stopped, using the direction sampled with that pulse. After reset that index is 0.
- R6: On retire, the status field (bits 15:0) is written with the value of per_stat. Reserved bits 31:16 always read back as 0, including after a software write of ones to them.
- R7: After a descriptor with wrap (bit 32) set, or after the last index of the store, the next descriptor is index 0. Otherwise it is the current index plus 1.
- R8: A retire raises irq for exactly one cycle, the cycle after the retire, when ctl_irq_en is 1 or the descriptor's interrupt flag (bit 35) is 1. With both 0 there is no pulse.
- R9: irq_pending is set with every irq pulse and holds until irq_clr is pulsed. When a set and a clear fall in the same cycle, the pending bit stays set.
- R10: After reset, idle=1 and irq, irq_pending, in_ready, out_valid, mem_we and mem_rd are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_go | input | 1 | Channel-enable pulse; starts an idle channel |
| ctl_dir | input | 1 | Direction sampled with ctl_go: 0 fill, 1 empty |
| ctl_irq_en | input | 1 | Interrupt on every normal completion |
| irq_clr | input | 1 | Write-one-to-clear pulse for irq_pending |
| sw_we | input | 1 | Software descriptor write strobe |
| sw_idx | input | $clog2(DESC_N) | Software descriptor index |
| sw_wdata | input | 64 | Software descriptor write data |
| sw_rdata | output | 64 | Descriptor at sw_idx, one cycle after the index |
| per_stat | input | 16 | Peripheral status word taken at retire |
| in_valid | input | 1 | Fill word valid |
| in_data | input | DATA_W | Fill word |
| in_eop | input | 1 | Fill word ends the packet |
| in_ready | output | 1 | Channel accepts a fill word |
| mem_we | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe; data due one cycle later |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| out_valid | output | 1 | Empty word valid |
| out_data | output | DATA_W | Empty word |
| out_eop | output | 1 | Empty word ends the packet |
| out_ready | input | 1 | Peripheral takes the empty word |
| irq | output | 1 | Interrupt pulse |
| irq_pending | output | 1 | Sticky interrupt flag |
| idle | output | 1 | Channel parked |

## Verification
A descriptor retire that raises an interrupt can fall in the same cycle as a software clear of the pending bit. The bench provokes this by pulsing irq_clr in the cycle that follows acceptance of the closing end-of-packet word of a descriptor with its interrupt flag set, which is the retire cycle. The result is judged correct when exactly one irq pulse follows and irq_pending is still 1 afterwards, meaning the set won over the clear. A later clear on its own must then drop the bit.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 12;
  localparam int STAT_W = 16;
  localparam int RSV_W  = 16;
  localparam int DESC_W = ADDR_W + LEN_W + 4 + RSV_W + STAT_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              irq;
    logic              last;
    logic              full;
    logic              wrap;
    logic [RSV_W-1:0]  rsv;
    logic [STAT_W-1:0] status;
  } desc_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_LOAD, S_FILL, S_ERD, S_EW1, S_EW2, S_EOUT, S_RET
  } ch_state_t;
endpackage

// File: rtl/fbdma_desc_ram.sv
module fbdma_desc_ram #(
  parameter int W = 64,
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 a_we,
  input  logic [$clog2(N)-1:0] a_addr,
  input  logic [W-1:0]         a_wdata,
  output logic [W-1:0]         a_rdata,
  input  logic                 b_we,
  input  logic [$clog2(N)-1:0] b_addr,
  input  logic [W-1:0]         b_wdata,
  output logic [W-1:0]         b_rdata
);
  logic [W-1:0] store [N];

  // channel write has priority over a software write in the same cycle
  always_ff @(posedge clk) begin
    if (b_we)      store[b_addr] <= b_wdata;
    else if (a_we) store[a_addr] <= a_wdata;
    a_rdata <= store[a_addr];
    b_rdata <= store[b_addr];
  end
endmodule

// File: rtl/fbdma_irq.sv
module fbdma_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      irq_o  <= set_i;
      pend_o <= set_i | (pend_o & ~clr_i);
    end
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    set_i |=> pend_o);
  assert_clear_only_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !pend_o);
  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
endmodule

// File: rtl/fbdma_engine.sv
module fbdma_engine
  import fbdma_pkg::*;
#(
  parameter int DESC_N = 8,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      go,
  input  logic                      dir_i,
  input  logic                      irq_en,
  input  desc_t                     ram_rdata,
  output logic                      ram_we,
  output desc_t                     ram_wdata,
  output logic [$clog2(DESC_N)-1:0] idx,
  input  logic [STAT_W-1:0]         per_stat,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         in_data,
  input  logic                      in_eop,
  output logic                      in_ready,
  output logic                      mem_we,
  output logic                      mem_rd,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_data,
  output logic                      out_eop,
  input  logic                      out_ready,
  output logic                      irq_set,
  output logic                      idle
);
  localparam int IDX_W = $clog2(DESC_N);

  ch_state_t         state;
  logic              dir_q;
  logic [LEN_W-1:0]  cnt;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_len;
  logic              cur_irq, cur_last, cur_full, cur_wrap, eop_seen;
  logic [LEN_W:0]    cnt_nx;
  logic              last_word;
  logic              unused_bits;

  assign unused_bits = ^{ram_rdata.rsv, ram_rdata.status};
  assign cnt_nx    = {1'b0, cnt} + 1'b1;
  assign last_word = cnt_nx >= {1'b0, cur_len};
  assign in_ready  = (state == S_FILL);
  assign idle      = (state == S_IDLE);
  assign ram_we    = (state == S_RET);
  assign irq_set   = (state == S_RET) && (irq_en || cur_irq);

  always_comb begin
    ram_wdata        = '0;
    ram_wdata.addr   = cur_addr;
    ram_wdata.len    = cur_len;
    ram_wdata.irq    = cur_irq;
    ram_wdata.wrap   = cur_wrap;
    ram_wdata.full   = ~dir_q;
    ram_wdata.last   = dir_q ? cur_last : eop_seen;
    ram_wdata.status = per_stat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; dir_q <= 1'b0; idx <= '0; cnt <= '0;
      cur_addr <= '0; cur_len <= '0; cur_irq <= 1'b0; cur_last <= 1'b0;
      cur_full <= 1'b0; cur_wrap <= 1'b0; eop_seen <= 1'b0;
      mem_we <= 1'b0; mem_rd <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      out_valid <= 1'b0; out_data <= '0; out_eop <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      mem_rd <= 1'b0;
      case (state)
        S_IDLE: if (go) begin dir_q <= dir_i; state <= S_RD; end
        S_RD:   state <= S_LOAD;
        S_LOAD: begin
          cur_addr <= ram_rdata.addr; cur_len  <= ram_rdata.len;
          cur_irq  <= ram_rdata.irq;  cur_last <= ram_rdata.last;
          cur_full <= ram_rdata.full; cur_wrap <= ram_rdata.wrap;
          cnt <= '0; eop_seen <= 1'b0;
          if (ram_rdata.full != dir_q) state <= S_IDLE;
          else                         state <= dir_q ? S_ERD : S_FILL;
        end
        S_FILL: if (in_valid) begin
          mem_we    <= 1'b1;
          mem_addr  <= cur_addr + ADDR_W'(cnt);
          mem_wdata <= in_data;
          cnt       <= cnt_nx[LEN_W-1:0];
          if (in_eop || last_word) begin
            eop_seen <= in_eop;
            state    <= S_RET;
          end
        end
        S_ERD: begin
          mem_rd   <= 1'b1;
          mem_addr <= cur_addr + ADDR_W'(cnt);
          state    <= S_EW1;
        end
        S_EW1: state <= S_EW2;
        S_EW2: begin
          out_valid <= 1'b1;
          out_data  <= mem_rdata;
          out_eop   <= cur_last && last_word;
          state     <= S_EOUT;
        end
        S_EOUT: if (out_ready) begin
          out_valid <= 1'b0;
          out_eop   <= 1'b0;
          cnt       <= cnt_nx[LEN_W-1:0];
          state     <= last_word ? S_RET : S_ERD;
        end
        S_RET: begin
          idx   <= (cur_wrap || idx == IDX_W'(DESC_N - 1)) ? '0 : idx + 1'b1;
          state <= S_RD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_fill_owned_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_FILL) |-> !cur_full);
  assert_empty_owned_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_EOUT) |-> cur_full);
  assert_write_in_buffer_R1: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ADDR_W'(mem_addr - cur_addr) < ADDR_W'(cur_len)));
  assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_RET && cur_wrap) |=> (idx == '0));
  assert_eop_needs_last_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eop) |-> cur_last);
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    idle |-> (!out_valid && !mem_we && !mem_rd));
endmodule

// File: rtl/fbdma_channel.sv
module fbdma_channel
  import fbdma_pkg::*;
#(
  parameter int DESC_N = 8,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ctl_go,
  input  logic                      ctl_dir,
  input  logic                      ctl_irq_en,
  input  logic                      irq_clr,
  input  logic                      sw_we,
  input  logic [$clog2(DESC_N)-1:0] sw_idx,
  input  logic [DESC_W-1:0]         sw_wdata,
  output logic [DESC_W-1:0]         sw_rdata,
  input  logic [STAT_W-1:0]         per_stat,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         in_data,
  input  logic                      in_eop,
  output logic                      in_ready,
  output logic                      mem_we,
  output logic                      mem_rd,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W-1:0]         mem_wdata,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_data,
  output logic                      out_eop,
  input  logic                      out_ready,
  output logic                      irq,
  output logic                      irq_pending,
  output logic                      idle
);
  desc_t                     sw_w, ch_w, ch_r;
  logic [DESC_W-1:0]         ch_r_raw;
  logic                      ch_we, irq_set;
  logic [$clog2(DESC_N)-1:0] ch_idx;

  always_comb begin
    sw_w     = desc_t'(sw_wdata);
    sw_w.rsv = '0;
  end
  assign ch_r = desc_t'(ch_r_raw);

  fbdma_desc_ram #(.W(DESC_W), .N(DESC_N)) u_ram (
    .clk(clk),
    .a_we(sw_we), .a_addr(sw_idx), .a_wdata(sw_w), .a_rdata(sw_rdata),
    .b_we(ch_we), .b_addr(ch_idx), .b_wdata(ch_w), .b_rdata(ch_r_raw)
  );

  fbdma_engine #(.DESC_N(DESC_N), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst(rst), .go(ctl_go), .dir_i(ctl_dir), .irq_en(ctl_irq_en),
    .ram_rdata(ch_r), .ram_we(ch_we), .ram_wdata(ch_w), .idx(ch_idx),
    .per_stat(per_stat), .in_valid(in_valid), .in_data(in_data),
    .in_eop(in_eop), .in_ready(in_ready), .mem_we(mem_we), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop),
    .out_ready(out_ready), .irq_set(irq_set), .idle(idle)
  );

  fbdma_irq u_irq (
    .clk(clk), .rst(rst), .set_i(irq_set), .clr_i(irq_clr),
    .irq_o(irq), .pend_o(irq_pending)
  );
endmodule

// File: tb/sim_fbdma_channel.sv
`timescale 1ns/1ps
module sim_fbdma_channel;
  localparam int N = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic ctl_go = 0, ctl_dir = 0, ctl_irq_en = 0, irq_clr = 0, sw_we = 0;
  logic [2:0]  sw_idx = '0;
  logic [63:0] sw_wdata = '0, sw_rdata;
  logic [15:0] per_stat = '0;
  logic in_valid = 0, in_eop = 0, in_ready, out_ready = 1;
  logic [31:0] in_data = '0, mem_wdata, mem_rdata, out_data;
  logic mem_we, mem_rd, out_valid, out_eop, irq, irq_pending, idle;
  logic [15:0] mem_addr;

  always #4 clk = ~clk;

  fbdma_channel #(.DESC_N(N), .DATA_W(32)) u0 (
    .clk(clk), .rst(rst), .ctl_go(ctl_go), .ctl_dir(ctl_dir),
    .ctl_irq_en(ctl_irq_en), .irq_clr(irq_clr), .sw_we(sw_we),
    .sw_idx(sw_idx), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .per_stat(per_stat), .in_valid(in_valid), .in_data(in_data),
    .in_eop(in_eop), .in_ready(in_ready), .mem_we(mem_we), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_eop(out_eop),
    .out_ready(out_ready), .irq(irq), .irq_pending(irq_pending), .idle(idle)
  );

  // bench memory
  logic [31:0] bmem [256];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) bmem[i] <= '0;
      mem_rdata <= '0;
    end else begin
      if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= bmem[mem_addr[7:0]];
    end
  end

  // reference model state (written by the stimulus process only)
  logic [15:0] d_addr [N];
  logic [11:0] d_len  [N];
  logic        d_irq [N], d_last [N], d_full [N], d_wrap [N];
  logic [15:0] d_stat [N];
  logic [31:0] mdl_mem [256];
  int m_idx = 0, m_cnt = 0, exp_irqs = 0, m_irq_en = 0;
  logic [15:0] exp_wa [64];
  logic [31:0] exp_wd [64];
  logic [31:0] exp_od [64];
  logic        exp_oe [64];
  int exp_wn = 0, exp_on = 0;
  int err_a = 0, chk_a = 0, err_m = 0, chk_m = 0;
  int obs_w = 0, obs_o = 0, irq_seen = 0;
  bit done = 0;

  // monitor: compared on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (irq) irq_seen++;
      if (mem_we) begin
        chk_m++;
        if (obs_w >= exp_wn || mem_addr != exp_wa[obs_w] || mem_wdata != exp_wd[obs_w]) begin
          err_m++;
          $display("FAIL R1 write %0d: addr=%h data=%h expected addr=%h data=%h", obs_w,
                   mem_addr, mem_wdata, exp_wa[obs_w[5:0]], exp_wd[obs_w[5:0]]);
        end
        obs_w++;
      end
      if (out_valid && out_ready) begin
        chk_m++;
        if (obs_o >= exp_on || out_data != exp_od[obs_o] || out_eop != exp_oe[obs_o]) begin
          err_m++;
          $display("FAIL R3 out %0d: data=%h eop=%b expected data=%h eop=%b", obs_o,
                   out_data, out_eop, exp_od[obs_o[5:0]], exp_oe[obs_o[5:0]]);
        end
        obs_o++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    chk_a++;
    if (!ok) begin
      err_a++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mpack(input int i);
    return {d_addr[i], d_len[i], d_irq[i], d_last[i], d_full[i], d_wrap[i], 16'h0, d_stat[i]};
  endfunction

  task automatic sw_write(input int i, input logic [15:0] a, input logic [11:0] l,
                          input logic irqf, input logic wr);
    d_addr[i] = a; d_len[i] = l; d_irq[i] = irqf; d_last[i] = 0; d_full[i] = 0;
    d_wrap[i] = wr; d_stat[i] = 16'h1234;
    @(negedge clk);
    sw_we = 1; sw_idx = 3'(i);
    sw_wdata = {a, l, irqf, 1'b0, 1'b0, wr, 16'hFFFF, 16'h1234};
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic check_desc(input int i, input string req);
    @(negedge clk); sw_idx = 3'(i);
    @(negedge clk);
    check(sw_rdata == mpack(i), req, sw_rdata, mpack(i));
  endtask

  task automatic model_retire(input logic eop);
    if (!d_full[m_idx]) begin d_full[m_idx] = 1; d_last[m_idx] = eop; end
    else d_full[m_idx] = 0;
    d_stat[m_idx] = per_stat;
    if (m_irq_en != 0 || d_irq[m_idx]) exp_irqs++;
    m_idx = (d_wrap[m_idx] || m_idx == N-1) ? 0 : m_idx + 1;
    m_cnt = 0;
  endtask

  task automatic push(input logic [31:0] d, input logic e);
    logic [15:0] a;
    a = d_addr[m_idx] + 16'(m_cnt);
    exp_wa[exp_wn] = a; exp_wd[exp_wn] = d; exp_wn++;
    mdl_mem[a[7:0]] = d;
    m_cnt++;
    if (e || m_cnt >= int'(d_len[m_idx])) model_retire(e);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d; in_eop = e;
    @(negedge clk);
    in_valid = 0; in_eop = 0;
  endtask

  task automatic model_empty();
    while (d_full[m_idx]) begin
      for (int k = 0; k < int'(d_len[m_idx]); k++) begin
        exp_od[exp_on] = mdl_mem[8'(d_addr[m_idx] + 16'(k))];
        exp_oe[exp_on] = d_last[m_idx] && (k == int'(d_len[m_idx]) - 1);
        exp_on++;
      end
      model_retire(1'b0);
    end
  endtask

  task automatic pulse_go(input logic dir);
    @(negedge clk); ctl_go = 1; ctl_dir = dir;
    @(negedge clk); ctl_go = 0;
  endtask

  task automatic wait_idle(input string req);
    int n;
    n = 0;
    repeat (4) @(negedge clk);
    while (!idle && n < 400) begin @(negedge clk); n++; end
    check(idle == 1'b1, req, 64'(idle), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", err_a + err_m + 1, chk_a + chk_m + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl_mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check(idle && !irq && !irq_pending && !in_ready && !out_valid && !mem_we && !mem_rd,
          "R10 reset outputs", {57'd0, idle, irq, irq_pending, in_ready, out_valid, mem_we, mem_rd},
          64'h40);

    sw_write(0, 16'h0010, 12'd3, 1'b0, 1'b0);
    sw_write(1, 16'h0020, 12'd4, 1'b1, 1'b0);
    sw_write(2, 16'h0030, 12'd2, 1'b0, 1'b1);
    check_desc(0, "R6 reserved bits read as zero after software write");

    // phase A: fill, channel interrupt enable off
    per_stat = 16'hA5C3; m_irq_en = 0; ctl_irq_en = 0;
    pulse_go(1'b0);
    push(32'hD000_0001, 0); push(32'hD000_0002, 0); push(32'hD000_0003, 0);
    push(32'hD000_0011, 0); push(32'hD000_0012, 1);
    // retire cycle of a descriptor with interrupt flag: clear at the same time
    irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    check(irq_pending == 1'b1, "R9 set wins over same-cycle clear", 64'(irq_pending), 64'd1);
    push(32'hD000_0021, 0); push(32'hD000_0022, 0);
    wait_idle("R4 idle at full descriptor in fill direction");
    check(obs_w == exp_wn, "R1 fill write count", 64'(obs_w), 64'(exp_wn));
    check(irq_seen == exp_irqs, "R8 interrupt only from flagged descriptor", 64'(irq_seen), 64'(exp_irqs));
    check_desc(0, "R2 length close last=0 full=1");
    check_desc(1, "R2 eop close last=1 full=1");
    check_desc(2, "R6 status written on retire");

    // R9 plain clear
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    check(irq_pending == 1'b0, "R9 clear drops pending", 64'(irq_pending), 64'd0);

    // phase B: empty, channel interrupt enable on, restart at index 0 (R5, R7)
    per_stat = 16'h3C01; m_irq_en = 1; ctl_irq_en = 1;
    model_empty();
    pulse_go(1'b1);
    wait_idle("R4 idle at empty descriptor in empty direction");
    check(obs_o == exp_on, "R3 empty word count incl. eop on last buffer", 64'(obs_o), 64'(exp_on));
    check(irq_seen == exp_irqs, "R8 interrupt per retire when enabled", 64'(irq_seen), 64'(exp_irqs));
    check(irq_pending == 1'b1, "R9 pending after interrupts", 64'(irq_pending), 64'd1);
    check_desc(0, "R3 full cleared after empty");
    check_desc(1, "R3 last kept after empty");
    check_desc(2, "R7 wrap descriptor retired");

    // phase C: wrong-state start, then resume in fill direction
    per_stat = 16'h0F0F; m_irq_en = 0; ctl_irq_en = 0;
    pulse_go(1'b1);
    wait_idle("R4 wrong-state start returns idle");
    repeat (5) @(negedge clk);
    check(!in_ready && !out_valid && idle, "R5 idle until enable pulse",
          {61'd0, in_ready, out_valid, idle}, 64'd1);
    check(obs_o == exp_on && irq_seen == exp_irqs, "R4 no output or interrupt on wrong state",
          64'(obs_o), 64'(exp_on));
    check_desc(0, "R4 descriptor unchanged on wrong state");
    pulse_go(1'b0);
    push(32'hE000_0001, 1);
    repeat (4) @(negedge clk);
    check_desc(0, "R5 resume fill at stopped index");
    check(irq_seen == exp_irqs, "R8 no interrupt when both enables off", 64'(irq_seen), 64'(exp_irqs));
    check(obs_w == exp_wn, "R1 resumed fill writes", 64'(obs_w), 64'(exp_wn));

    done = 1;
    $display("Result: errors=%0d of %0d checks", err_a + err_m, chk_a + chk_m);
    $finish;
  end
endmodule